// File: doc/BRIEF.md
# Port Access Decoder with Mailbox Flag

This block turns the control pins of one port of a two-FIFO bidirectional buffer into single-cycle operation strobes. A shared set of controls (active-low chip select, a direction select, an enable and a mailbox select) carries both FIFO traffic and mailbox traffic. The block produces one strobe per clock edge at most: FIFO write, FIFO read, mailbox write or mailbox read. It also decides when the port's data bus is driven, and which source drives it: the FIFO output register or the incoming mailbox register.

The block also holds the active-low full flag of the incoming mailbox. The mailbox-write strobe of the opposite port clears this flag, and a local mailbox read sets it again. The FIFO arrays, the mailbox data registers and the ready-flag logic sit outside the block. The FIFO ready flags arrive as plain inputs.

The direction polarity is a parameter. One RTL body serves both ends of the device. On the first port, a high direction select means write. On the second port, the same level means read. Each instance runs on its own port clock.

Top module: `port_access_decoder`

## Requirements
- R1: `bus_oe` is high exactly when `cs_n` is low and the port is in read direction. With PORT_B=0, read direction is `wr_rd`=0. With PORT_B=1, read direction is `wr_rd`=1.
- R2: `fifo_wr` is high exactly when `cs_n`=0, the port is in write direction, `en`=1, `mbox_sel`=0 and `in_ready`=1.
- R3: `fifo_rd` is high exactly when `cs_n`=0, the port is in read direction, `en`=1, `mbox_sel`=0 and `out_ready`=1.
- R4: `mbox_wr` is high exactly when `cs_n`=0, the port is in write direction, `en`=1 and `mbox_sel`=1. `in_ready` has no effect on it.
- R5: `mbox_rd` is high exactly when `cs_n`=0, the port is in read direction, `en`=1 and `mbox_sel`=1. `out_ready` has no effect on it.
- R6: While `bus_oe` is high, `bus_out` equals `mbox_in_q` if `mbox_sel`=1 and `fifo_q` if `mbox_sel`=0, whatever the level of `en`. While `bus_oe` is low, `bus_out` is all zeros.
- R7: With `en` low or `cs_n` high, all four strobes are low, even while the bus is driven.
- R8: `mbox_full_n` is 1 during and after reset. A clock edge with `remote_mbox_wr`=1 makes it 0. An edge with `mbox_rd`=1 and no remote write makes it 1. If both occur on the same edge, the remote write wins. Otherwise the flag holds its value.
- R9: At most one of the four strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| wr_rd | input | 1 | Direction select; meaning set by PORT_B |
| en | input | 1 | Operation enable |
| mbox_sel | input | 1 | Selects mailbox instead of FIFO |
| in_ready | input | 1 | FIFO being written can accept a word |
| out_ready | input | 1 | FIFO being read has a word in its output register |
| fifo_q | input | DATA_W | FIFO output register contents |
| mbox_in_q | input | DATA_W | Incoming mailbox register contents |
| remote_mbox_wr | input | 1 | Mailbox write strobe from the opposite port, in this clock domain |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_rd | output | 1 | FIFO read strobe |
| mbox_wr | output | 1 | Outgoing mailbox write strobe |
| mbox_rd | output | 1 | Incoming mailbox read strobe |
| bus_oe | output | 1 | Data bus output enable |
| bus_out | output | DATA_W | Value to drive on the data bus |
| mbox_full_n | output | 1 | Incoming mailbox full flag, active low |

## Verification
The bench builds two instances. One has PORT_B=0 and DATA_W=36. The other has PORT_B=1 and DATA_W=12. Each instance's mailbox-write strobe feeds the other's `remote_mbox_wr`, so both direction polarities and both bus widths run in the same pass. Because of this cross-coupling, random stimulus also hits the case where the mailbox is written from the far side on the same edge as it is read locally. The narrow width also checks that the bus multiplexer follows DATA_W rather than a fixed 36.

// File: rtl/pad_pkg.sv
package pad_pkg;
  typedef enum logic [2:0] {
    PF_IDLE    = 3'd0,
    PF_FIFO_WR = 3'd1,
    PF_FIFO_RD = 3'd2,
    PF_MBOX_WR = 3'd3,
    PF_MBOX_RD = 3'd4
  } port_fn_e;

  typedef enum logic {
    SRC_FIFO = 1'b0,
    SRC_MBOX = 1'b1
  } bus_src_e;
endpackage

// File: rtl/port_ctrl_decode.sv
module port_ctrl_decode
  import pad_pkg::*;
#(
  parameter bit PORT_B = 1'b0
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     cs_n,
  input  logic     wr_rd,
  input  logic     en,
  input  logic     mbox_sel,
  input  logic     in_ready,
  input  logic     out_ready,
  output port_fn_e fn,
  output logic     oe,
  output bus_src_e src
);
  logic wr_dir;
  logic active;

  // Direction polarity chosen at elaboration time
  generate
    if (PORT_B) begin : g_pol_b
      assign wr_dir = ~wr_rd;
    end else begin : g_pol_a
      assign wr_dir = wr_rd;
    end
  endgenerate

  assign active = ~cs_n & en;
  assign oe     = ~cs_n & ~wr_dir;
  assign src    = mbox_sel ? SRC_MBOX : SRC_FIFO;

  always_comb begin
    fn = PF_IDLE;
    if (active) begin
      if (wr_dir) begin
        if (mbox_sel)      fn = PF_MBOX_WR;
        else if (in_ready) fn = PF_FIFO_WR;
      end else begin
        if (mbox_sel)       fn = PF_MBOX_RD;
        else if (out_ready) fn = PF_FIFO_RD;
      end
    end
  end

  // R7: nothing is decoded while disabled or deselected
  assert_idle_when_off_R7: assert property (@(posedge clk) disable iff (rst)
    (cs_n || !en) |-> (fn == PF_IDLE));
endmodule

// File: rtl/port_bus_mux.sv
module port_bus_mux
  import pad_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  logic              oe,
  input  bus_src_e          src,
  input  logic [DATA_W-1:0] fifo_q,
  input  logic [DATA_W-1:0] mbox_q,
  output logic [DATA_W-1:0] bus_out
);
  always_comb begin
    bus_out = '0;
    if (oe) bus_out = (src == SRC_MBOX) ? mbox_q : fifo_q;
  end
endmodule

// File: rtl/mbox_flag.sv
module mbox_flag (
  input  logic clk,
  input  logic rst,
  input  logic remote_wr,
  input  logic local_rd,
  output logic full_n
);
  always_ff @(posedge clk) begin
    if (rst)            full_n <= 1'b1;
    else if (remote_wr) full_n <= 1'b0;
    else if (local_rd)  full_n <= 1'b1;
  end

  assert_flag_set_R8: assert property (@(posedge clk) disable iff (rst)
    remote_wr |=> !full_n);
  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (local_rd && !remote_wr) |=> full_n);
  assert_flag_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!local_rd && !remote_wr) |=> $stable(full_n));
endmodule

// File: rtl/port_access_decoder.sv
module port_access_decoder
  import pad_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter bit PORT_B = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              wr_rd,
  input  logic              en,
  input  logic              mbox_sel,
  input  logic              in_ready,
  input  logic              out_ready,
  input  logic [DATA_W-1:0] fifo_q,
  input  logic [DATA_W-1:0] mbox_in_q,
  input  logic              remote_mbox_wr,
  output logic              fifo_wr,
  output logic              fifo_rd,
  output logic              mbox_wr,
  output logic              mbox_rd,
  output logic              bus_oe,
  output logic [DATA_W-1:0] bus_out,
  output logic              mbox_full_n
);
  port_fn_e fn;
  bus_src_e src;

  port_ctrl_decode #(.PORT_B(PORT_B)) u_dec (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_rd(wr_rd), .en(en),
    .mbox_sel(mbox_sel), .in_ready(in_ready), .out_ready(out_ready),
    .fn(fn), .oe(bus_oe), .src(src)
  );

  assign fifo_wr = (fn == PF_FIFO_WR);
  assign fifo_rd = (fn == PF_FIFO_RD);
  assign mbox_wr = (fn == PF_MBOX_WR);
  assign mbox_rd = (fn == PF_MBOX_RD);

  port_bus_mux #(.DATA_W(DATA_W)) u_mux (
    .oe(bus_oe), .src(src), .fifo_q(fifo_q), .mbox_q(mbox_in_q), .bus_out(bus_out)
  );

  mbox_flag u_flag (
    .clk(clk), .rst(rst), .remote_wr(remote_mbox_wr), .local_rd(mbox_rd),
    .full_n(mbox_full_n)
  );

  assert_oe_needs_select_R1: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> !cs_n);
  assert_fifo_wr_ready_R2: assert property (@(posedge clk) disable iff (rst)
    fifo_wr |-> (in_ready && !mbox_sel && !bus_oe));
  assert_fifo_rd_ready_R3: assert property (@(posedge clk) disable iff (rst)
    fifo_rd |-> (out_ready && !mbox_sel && bus_oe));
  assert_mbox_wr_sel_R4: assert property (@(posedge clk) disable iff (rst)
    mbox_wr |-> (mbox_sel && !bus_oe));
  assert_mbox_rd_sel_R5: assert property (@(posedge clk) disable iff (rst)
    mbox_rd |-> (mbox_sel && bus_oe));
  assert_bus_mbox_src_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_oe && mbox_sel) |-> (bus_out == mbox_in_q));
  assert_no_strobe_disabled_R7: assert property (@(posedge clk) disable iff (rst)
    !en |-> !(fifo_wr || fifo_rd || mbox_wr || mbox_rd));
  assert_one_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fifo_wr, fifo_rd, mbox_wr, mbox_rd}));
endmodule

// File: tb/tb_port_access_decoder.sv
`timescale 1ns/1ps
module tb_port_access_decoder;
  localparam int WA = 36;
  localparam int WB = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic a_cs_n, a_wr, a_en, a_ms, a_ir, a_or;
  logic b_cs_n, b_wr, b_en, b_ms, b_ir, b_or;
  logic [WA-1:0] a_fq, a_mq, a_bus;
  logic [WB-1:0] b_fq, b_mq, b_bus;
  logic a_fw, a_fr, a_mw, a_mr, a_oe, a_full_n;
  logic b_fw, b_fr, b_mw, b_mr, b_oe, b_full_n;

  port_access_decoder #(.DATA_W(WA), .PORT_B(1'b0)) dut (
    .clk(clk), .rst(rst), .cs_n(a_cs_n), .wr_rd(a_wr), .en(a_en), .mbox_sel(a_ms),
    .in_ready(a_ir), .out_ready(a_or), .fifo_q(a_fq), .mbox_in_q(a_mq),
    .remote_mbox_wr(b_mw), .fifo_wr(a_fw), .fifo_rd(a_fr), .mbox_wr(a_mw),
    .mbox_rd(a_mr), .bus_oe(a_oe), .bus_out(a_bus), .mbox_full_n(a_full_n)
  );

  port_access_decoder #(.DATA_W(WB), .PORT_B(1'b1)) dut_b (
    .clk(clk), .rst(rst), .cs_n(b_cs_n), .wr_rd(b_wr), .en(b_en), .mbox_sel(b_ms),
    .in_ready(b_ir), .out_ready(b_or), .fifo_q(b_fq), .mbox_in_q(b_mq),
    .remote_mbox_wr(a_mw), .fifo_wr(b_fw), .fifo_rd(b_fr), .mbox_wr(b_mw),
    .mbox_rd(b_mr), .bus_oe(b_oe), .bus_out(b_bus), .mbox_full_n(b_full_n)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(input string req, input string what,
                     input logic [35:0] got, input logic [35:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  // reference model state
  bit fa_n = 1, fb_n = 1;

  typedef struct packed {
    logic oe, fw, fr, mw, mr;
  } exp_t;

  function automatic exp_t model(input bit is_b, input logic cs_n, wr, en, ms, ir, orr);
    exp_t e;
    bit wd  = is_b ? !wr : wr;
    bit act = !cs_n && en;
    e.oe = !cs_n && !wd;
    e.fw = act && wd && !ms && ir;
    e.fr = act && !wd && !ms && orr;
    e.mw = act && wd && ms;
    e.mr = act && !wd && ms;
    return e;
  endfunction

  task automatic check_a(input exp_t e);
    logic [WA-1:0] eb;
    eb = !e.oe ? '0 : (a_ms ? a_mq : a_fq);
    chk("R1", "A oe", 36'(a_oe), 36'(e.oe));
    chk("R2", "A fifo_wr", 36'(a_fw), 36'(e.fw));
    chk("R3", "A fifo_rd", 36'(a_fr), 36'(e.fr));
    chk("R4", "A mbox_wr", 36'(a_mw), 36'(e.mw));
    chk("R5", "A mbox_rd", 36'(a_mr), 36'(e.mr));
    chk("R6", "A bus", a_bus, eb);
    chk("R8", "A full_n", 36'(a_full_n), 36'(fa_n));
    chk("R9", "A strobe count", 36'($countones({a_fw, a_fr, a_mw, a_mr}) <= 1), 36'd1);
    if (!a_en || a_cs_n)
      chk("R7", "A strobes off", 36'({a_fw, a_fr, a_mw, a_mr}), 36'd0);
  endtask

  task automatic check_b(input exp_t e);
    logic [WB-1:0] eb;
    eb = !e.oe ? '0 : (b_ms ? b_mq : b_fq);
    chk("R1", "B oe", 36'(b_oe), 36'(e.oe));
    chk("R2", "B fifo_wr", 36'(b_fw), 36'(e.fw));
    chk("R3", "B fifo_rd", 36'(b_fr), 36'(e.fr));
    chk("R4", "B mbox_wr", 36'(b_mw), 36'(e.mw));
    chk("R5", "B mbox_rd", 36'(b_mr), 36'(e.mr));
    chk("R6", "B bus", 36'(b_bus), 36'(eb));
    chk("R8", "B full_n", 36'(b_full_n), 36'(fb_n));
    chk("R9", "B strobe count", 36'($countones({b_fw, b_fr, b_mw, b_mr}) <= 1), 36'd1);
    if (!b_en || b_cs_n)
      chk("R7", "B strobes off", 36'({b_fw, b_fr, b_mw, b_mr}), 36'd0);
  endtask

  task automatic step_and_check();
    exp_t ea, eb;
    #1;
    ea = model(1'b0, a_cs_n, a_wr, a_en, a_ms, a_ir, a_or);
    eb = model(1'b1, b_cs_n, b_wr, b_en, b_ms, b_ir, b_or);
    check_a(ea);
    check_b(eb);
    // flag updates take effect on the coming edge (R8: remote write wins)
    if (eb.mw)      fa_n = 0;
    else if (ea.mr) fa_n = 1;
    if (ea.mw)      fb_n = 0;
    else if (eb.mr) fb_n = 1;
  endtask

  task automatic drive_a(input logic cs_n, wr, en, ms, ir, orr);
    a_cs_n = cs_n; a_wr = wr; a_en = en; a_ms = ms; a_ir = ir; a_or = orr;
  endtask

  task automatic drive_b(input logic cs_n, wr, en, ms, ir, orr);
    b_cs_n = cs_n; b_wr = wr; b_en = en; b_ms = ms; b_ir = ir; b_or = orr;
  endtask

  initial begin
    drive_a(1, 0, 0, 0, 0, 0);
    drive_b(1, 0, 0, 0, 0, 0);
    a_fq = 36'h123456789; a_mq = 36'hABCDEF012;
    b_fq = 12'h5A5;       b_mq = 12'h3C3;
    repeat (3) @(negedge clk);
    rst = 0;
    // reset state: flags high, no strobes, bus idle (R8, R7)
    #1;
    chk("R8", "A full_n after reset", 36'(a_full_n), 36'd1);
    chk("R8", "B full_n after reset", 36'(b_full_n), 36'd1);
    chk("R7", "A idle after reset", 36'({a_fw, a_fr, a_mw, a_mr, a_oe}), 36'd0);

    // directed: A writes mailbox, B reads it on the following cycle
    @(negedge clk); drive_a(0, 1, 1, 1, 0, 0); drive_b(1, 0, 0, 0, 0, 0); step_and_check();
    @(negedge clk); drive_a(1, 0, 0, 0, 0, 0); drive_b(0, 1, 1, 1, 0, 0); step_and_check();
    // directed: same-edge far write and local read on B (R8 write wins)
    @(negedge clk); drive_a(0, 1, 1, 1, 0, 0); drive_b(0, 1, 1, 1, 0, 0); step_and_check();
    // directed: read direction with enable low still drives bus (R6, R7)
    @(negedge clk); drive_a(0, 0, 0, 1, 1, 1); drive_b(0, 1, 0, 0, 1, 1); step_and_check();
    // directed: not-ready FIFO suppresses only FIFO strobes (R2, R3)
    @(negedge clk); drive_a(0, 1, 1, 0, 0, 1); drive_b(0, 1, 1, 0, 1, 0); step_and_check();
    @(negedge clk); drive_a(1, 0, 0, 0, 0, 0); drive_b(1, 0, 0, 0, 0, 0); step_and_check();

    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      drive_a(($urandom % 4) == 0, $urandom, $urandom, ($urandom % 3) == 0, $urandom, $urandom);
      drive_b(($urandom % 4) == 0, $urandom, $urandom, ($urandom % 3) == 0, $urandom, $urandom);
      a_fq = {$urandom, $urandom} & {WA{1'b1}};
      a_mq = {$urandom, $urandom} & {WA{1'b1}};
      b_fq = WB'($urandom);
      b_mq = WB'($urandom);
      step_and_check();
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule